// File: doc/BRIEF.md
# Synthesizer Power-Down Sequencing Controller

This block chooses the operating mode of a frequency-synthesizer core. It takes three inputs: an external chip-enable pin and two programmed control bits, one that requests power-down and one that selects the immediate flavour. From them it drives the enables for the oscillator buffer, the prescaler, the phase detector and the charge pump. It also drives one control that holds the reference and feedback dividers at their load point, and one request that puts the output pins into high impedance.

There are two ways to power down.
- The immediate flavour switches everything off at the next timing-clock edge. A low chip-enable does the same with no clock at all.
- The deferred flavour keeps the core running until the charge pump reports, through a completion strobe, that its current pulse has ended.

On wake-up every functional enable asserts at once. The dividers are held for a bias-settling time and then released together, so the reference and feedback paths start counting aligned. The settling time is given in nanoseconds and converted to timing-clock cycles, rounded up.

Because chip-enable is asynchronous, a two-flop synchroniser feeds it to the sequencing logic. Its low level still acts on the outputs directly. The control bits and the completion strobe are expected to come from the timing-clock domain.

Top module: `synth_pwr_seq`

## Requirements
- R1: While chip_en is low, all four functional enables are 0, pin_hiz is 1 and div_hold is 1, with no clock edge needed.
- R2: With chip_en high and pd_req clear, the enables rise on the third clock edge after chip_en rises (two synchroniser stages plus the state register).
- R3: With chip_en high and both pd_req and pd_now set, every enable is 0 after the next clock edge.
- R4: With chip_en high, pd_req set and pd_now clear, the enables stay on until a cycle in which pulse_done is sampled high, and are 0 after that edge.
- R5: A deferred power-down that is still waiting is cancelled if pd_req is cleared before pulse_done arrives. A later pulse_done then has no effect and the enables stay on.
- R6: On wake-up the four enables assert together and div_hold stays 1 for exactly SETTLE_CYC clock cycles, then falls to 0. SETTLE_CYC = ceil(SETTLE_NS*CLK_KHZ/1e6), which is 30 with the defaults.
- R7: Any power-down request during the settling window switches the enables off at the next edge. The following wake-up restarts the full SETTLE_CYC window.
- R8: pin_hiz is 1 exactly when the functional enables are 0.
- R9: During reset the block is off: enables 0, pin_hiz 1 and div_hold 1, whatever the other inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running timing clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_en | input | 1 | External chip-enable pin, asynchronous |
| pd_req | input | 1 | Programmed bit: request power-down |
| pd_now | input | 1 | Programmed bit: 1 = immediate, 0 = after the next charge-pump pulse |
| pulse_done | input | 1 | Strobe: a charge-pump pulse has completed |
| osc_buf_en | output | 1 | Oscillator buffer enable |
| presc_en | output | 1 | Prescaler enable |
| pfd_en | output | 1 | Phase detector enable |
| cp_en | output | 1 | Charge pump enable |
| div_hold | output | 1 | Hold both dividers at their load point |
| pin_hiz | output | 1 | Request high impedance on the output pins |

## Verification
A stuck or wrong state shows up quickly at the ports.
- A state that stays off shows as enables missing on the third edge after wake-up.
- A timer that miscounts moves the fall of div_hold by one or more cycles. The bench checks that edge on the exact cycle.
- A lost cancel, or a deferred power-down that ignores pulse_done, shows at the first strobe: the enables are wrong on the very next sample.
- A missing combinational path from chip_en shows before any clock edge at all.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL   = 2'd0,
    MODE_SYNC_PD  = 2'd1,
    MODE_ASYNC_PD = 2'd2
  } mode_t;

  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_SETTLE = 2'd1,
    ST_RUN    = 2'd2,
    ST_PEND   = 2'd3
  } state_t;

  // Settling cycles = ceil(ns * kHz / 1e6), never below one.
  function automatic int settle_cycles(input int ns, input int khz);
    longint prod;
    int cyc;
    prod = longint'(ns) * longint'(khz);
    cyc  = int'((prod + 64'd999999) / 64'd1000000);
    return (cyc < 1) ? 1 : cyc;
  endfunction

endpackage

// File: rtl/pwr_ce_sync.sv
module pwr_ce_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], async_in};
  end

  assign sync_out = stage_q[1];
endmodule

// File: rtl/pwr_mode_dec.sv
module pwr_mode_dec
  import pwr_seq_pkg::*;
(
  input  logic  ce_ok,
  input  logic  pd_req,
  input  logic  pd_now,
  output mode_t mode
);
  always_comb begin
    if (!ce_ok)       mode = MODE_ASYNC_PD;
    else if (!pd_req) mode = MODE_NORMAL;
    else if (!pd_now) mode = MODE_SYNC_PD;
    else              mode = MODE_ASYNC_PD;
  end
endmodule

// File: rtl/pwr_settle_timer.sv
module pwr_settle_timer #(
  parameter int CYCLES = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic count,
  output logic done
);
  localparam int W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [W-1:0] START = W'(CYCLES - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (load)              cnt_q <= START;
    else if (count && !done)    cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/synth_pwr_seq.sv
module synth_pwr_seq
  import pwr_seq_pkg::*;
#(
  parameter int CLK_KHZ   = 20000,
  parameter int SETTLE_NS = 1500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chip_en,
  input  logic pd_req,
  input  logic pd_now,
  input  logic pulse_done,
  output logic osc_buf_en,
  output logic presc_en,
  output logic pfd_en,
  output logic cp_en,
  output logic div_hold,
  output logic pin_hiz
);
  localparam int SETTLE_CYC = settle_cycles(SETTLE_NS, CLK_KHZ);

  logic   ce_sync;
  mode_t  mode_req;
  state_t state_q, state_d;
  logic   settle_load, settle_done, active;

  pwr_ce_sync u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (chip_en),
    .sync_out (ce_sync)
  );

  pwr_mode_dec u_dec (
    .ce_ok  (ce_sync),
    .pd_req (pd_req),
    .pd_now (pd_now),
    .mode   (mode_req)
  );

  assign settle_load = (state_q == ST_OFF) && (mode_req == MODE_NORMAL);

  pwr_settle_timer #(.CYCLES(SETTLE_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (settle_load),
    .count (state_q == ST_SETTLE),
    .done  (settle_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:    if (mode_req == MODE_NORMAL) state_d = ST_SETTLE;
      ST_SETTLE: begin
        if (mode_req != MODE_NORMAL) state_d = ST_OFF;
        else if (settle_done)        state_d = ST_RUN;
      end
      ST_RUN: begin
        if (mode_req == MODE_ASYNC_PD)     state_d = ST_OFF;
        else if (mode_req == MODE_SYNC_PD) state_d = ST_PEND;
      end
      ST_PEND: begin
        if (mode_req == MODE_ASYNC_PD)    state_d = ST_OFF;
        else if (mode_req == MODE_NORMAL) state_d = ST_RUN;
        else if (pulse_done)              state_d = ST_OFF;
      end
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_d;
  end

  // Raw chip_en gates the outputs so a low pin acts without a clock.
  assign active     = chip_en && (state_q != ST_OFF);
  assign osc_buf_en = active;
  assign presc_en   = active;
  assign pfd_en     = active;
  assign cp_en      = active;
  assign pin_hiz    = !active;
  assign div_hold   = !active || (state_q == ST_SETTLE);
endmodule

// File: rtl/synth_pwr_seq_chk.sv
module synth_pwr_seq_chk
  import pwr_seq_pkg::*;
#(
  parameter int SETTLE_CYC = 30
) (
  input logic   clk,
  input logic   rst_n,
  input logic   chip_en,
  input logic   pulse_done,
  input logic   osc_buf_en,
  input logic   presc_en,
  input logic   pfd_en,
  input logic   cp_en,
  input logic   div_hold,
  input logic   pin_hiz,
  input mode_t  mode_req,
  input state_t state_q
);
  logic all_on;
  logic [15:0] hold_run;

  assign all_on = osc_buf_en && presc_en && pfd_en && cp_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 hold_run <= '0;
    else if (all_on && div_hold) hold_run <= hold_run + 1'b1;
    else                        hold_run <= '0;
  end

  a_r1_ce_low_off: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |-> (!osc_buf_en && !presc_en && !pfd_en && !cp_en && pin_hiz && div_hold));

  a_r3_async_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_req == MODE_ASYNC_PD) |=> !cp_en);

  a_r4_sync_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_en && !div_hold && mode_req == MODE_SYNC_PD && !pulse_done) |=> (state_q != ST_OFF));

  a_r4_pulse_off: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PEND && pulse_done && mode_req == MODE_SYNC_PD) |=> !cp_en);

  a_r6_wake_held: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cp_en) |-> (div_hold && all_on));

  a_r6_settle_len: assert property (@(posedge clk) disable iff (!rst_n)
    (all_on && $fell(div_hold)) |-> (32'(hold_run) == SETTLE_CYC));
endmodule

bind synth_pwr_seq synth_pwr_seq_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .chip_en    (chip_en),
  .pulse_done (pulse_done),
  .osc_buf_en (osc_buf_en),
  .presc_en   (presc_en),
  .pfd_en     (pfd_en),
  .cp_en      (cp_en),
  .div_hold   (div_hold),
  .pin_hiz    (pin_hiz),
  .mode_req   (mode_req),
  .state_q    (state_q)
);

// File: tb/synth_pwr_seq_test.sv
module synth_pwr_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_KHZ    = 20000;
  localparam int SETTLE_NS  = 1500;
  // Restated independently: ceil(1500 ns at 20 MHz) = 30 cycles.
  localparam int N_SETTLE   = (SETTLE_NS * (CLK_KHZ / 1000) + 999) / 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chip_en = 1'b0, pd_req = 1'b0, pd_now = 1'b0, pulse_done = 1'b0;
  logic osc_buf_en, presc_en, pfd_en, cp_en, div_hold, pin_hiz;
  int total = 0, bad = 0;

  synth_pwr_seq #(.CLK_KHZ(CLK_KHZ), .SETTLE_NS(SETTLE_NS)) uut (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .pd_req(pd_req),
    .pd_now(pd_now), .pulse_done(pulse_done), .osc_buf_en(osc_buf_en),
    .presc_en(presc_en), .pfd_en(pfd_en), .cp_en(cp_en),
    .div_hold(div_hold), .pin_hiz(pin_hiz)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // exp_on: enables expected on; exp_hold: div_hold expected.
  task automatic check(input string req, input logic exp_on, input logic exp_hold);
    logic [5:0] got, exp;
    got = {osc_buf_en, presc_en, pfd_en, cp_en, div_hold, pin_hiz};
    exp = {exp_on, exp_on, exp_on, exp_on, exp_hold, !exp_on};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b (en4,hold,hiz) at %0t", req, got, exp, $time);
    end
  endtask

  task automatic wake_full;
    chip_en = 1'b1; pd_req = 1'b0; pd_now = 1'b0;
    step(3 + N_SETTLE);
  endtask

  task automatic t_reset;
    chip_en = 1'b1;
    step(4);
    check("R9 reset off", 1'b0, 1'b1);
    rst_n = 1'b1;
    chip_en = 1'b0;
    step(3);
    check("R9 after reset", 1'b0, 1'b1);
  endtask

  task automatic t_wake;
    chip_en = 1'b1; pd_req = 1'b0;
    step(2);
    check("R2 not yet on", 1'b0, 1'b1);
    step(1);
    check("R2 on third edge", 1'b1, 1'b1);
    step(N_SETTLE - 1);
    check("R6 still held", 1'b1, 1'b1);
    step(1);
    check("R6 released", 1'b1, 1'b0);
    check("R8 pins driven", 1'b1, 1'b0);
  endtask

  task automatic t_ce_low;
    chip_en = 1'b0;
    #1;
    check("R1 ce low no clock", 1'b0, 1'b1);
    step(5);
    check("R1 ce low held", 1'b0, 1'b1);
  endtask

  task automatic t_async;
    wake_full();
    pd_req = 1'b1; pd_now = 1'b1;
    #1;
    check("R3 before edge", 1'b1, 1'b0);
    step(1);
    check("R3 off after edge", 1'b0, 1'b1);
    check("R8 pins hiz", 1'b0, 1'b1);
  endtask

  task automatic t_sync;
    wake_full();
    pd_req = 1'b1; pd_now = 1'b0;
    step(6);
    check("R4 waits for pulse", 1'b1, 1'b0);
    pulse_done = 1'b1;
    step(1);
    pulse_done = 1'b0;
    check("R4 off after pulse", 1'b0, 1'b1);
  endtask

  task automatic t_cancel;
    wake_full();
    pd_req = 1'b1; pd_now = 1'b0;
    step(3);
    pd_req = 1'b0;
    step(3);
    pulse_done = 1'b1;
    step(1);
    pulse_done = 1'b0;
    step(1);
    check("R5 cancel keeps on", 1'b1, 1'b0);
  endtask

  task automatic t_restart;
    chip_en = 1'b1; pd_req = 1'b0; pd_now = 1'b0;
    step(3 + 10);
    check("R7 mid settle", 1'b1, 1'b1);
    pd_req = 1'b1; pd_now = 1'b0;
    step(1);
    check("R7 sync pd in settle off", 1'b0, 1'b1);
    pd_req = 1'b0;
    step(1);
    check("R7 rewake held", 1'b1, 1'b1);
    step(N_SETTLE - 1);
    check("R7 full window held", 1'b1, 1'b1);
    step(1);
    check("R7 released", 1'b1, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_wake();
    t_ce_low();
    t_async();
    t_ce_low();
    t_sync();
    t_ce_low();
    t_cancel();
    t_ce_low();
    t_restart();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule